// File: doc/BRIEF.md
# Power-On Strap Capture Sequencer

This block turns five dual-purpose clock pins into configuration inputs for a short time after power comes up. While the sampling window runs, all five output enables stay low so that external strap resistors set the pad levels. When the window ends, the sequencer records those levels as configuration bits: a three-bit default frequency code, a mode bit and an SDRAM clock source select. One reference cycle later it turns the five drivers on as clock outputs.

The window is counted in reference clock cycles. The default of 28,636 cycles gives about 2 ms at 14.318 MHz. Each pad level passes through a synchronizer. The sequencer records the levels only when every synchronized value has matched on two consecutive samples, so a pad that is still settling makes the window longer. The recorded bits keep their values while the power-good input stays high. If power-good drops, the sequencer clears the bits, turns the drivers off and arms a new window.

Top module: `pinstrap_sequencer`

## Requirements
- R1: While `rst_n` is low, all `pin_oe` bits, `clocks_live`, `boot_fs`, `mode_strap` and `sdsel_strap` are 0. The reset acts at once, without waiting for a clock edge.
- R2: After `power_good` rises, every `pin_oe` bit stays 0 for a window of at least `WIN_CYCLES` reference cycles.
- R3: With stable pads, the strap outputs read 0 up to and including clock edge `WIN_CYCLES`+2 after `power_good` rises. At edge `WIN_CYCLES`+3 they take the pad levels with this mapping: `sdsel_strap` = `pin_sense[0]`, `boot_fs[2]` = `pin_sense[1]`, `mode_strap` = `pin_sense[2]`, `boot_fs[1]` = `pin_sense[3]`, `boot_fs[0]` = `pin_sense[4]`.
- R4: All five `pin_oe` bits and `clocks_live` go to 1 exactly one edge after the strap outputs are loaded, and never on the same edge.
- R5: Once the strap outputs are loaded, changes on `pin_sense` have no effect on them while `power_good` stays high.
- R6: The strap outputs are loaded only after every synchronized pad value has matched on two consecutive samples. If the last pad change occurs just before edge k, the load happens at edge max(`WIN_CYCLES`+3, k+3).
- R7: A low level on `power_good` brings `pin_oe`, `clocks_live` and all strap outputs to 0 on the third edge after the fall. A new rise of `power_good` restarts the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that counts the window |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| power_good | input | 1 | Main supply valid; asynchronous, synchronized inside the block |
| pin_sense | input | 5 | Pad input levels: 0 REF, 1 PCI_F, 2 AGP_F, 3 48 MHz, 4 24 MHz |
| pin_oe | output | 5 | Driver enables for the five pads, same index order |
| boot_fs | output | 3 | Latched default frequency code |
| mode_strap | output | 1 | Latched mode bit |
| sdsel_strap | output | 1 | Latched SDRAM clock source select |
| clocks_live | output | 1 | High when the pads run as clock outputs |

## Verification
Every result is tied to a fixed edge count, measured from the edge that follows a stimulus applied on a falling edge. With quiet pads, the strap outputs load on edge `WIN_CYCLES`+3 and the drivers enable on edge `WIN_CYCLES`+4. When a pad toggles late, the load moves to three edges after its last change. A power-good fall shows at the outputs on the third edge. The bench counts edges from each stimulus and samples 2 ns after the edge where a result is due. It also samples the edge before, where the old value must still hold, so a result that arrives one cycle early or late fails.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int unsigned PIN_COUNT = 5;

  localparam int unsigned PIN_REF  = 0;
  localparam int unsigned PIN_PCIF = 1;
  localparam int unsigned PIN_AGPF = 2;
  localparam int unsigned PIN_C48  = 3;
  localparam int unsigned PIN_C24  = 4;

  typedef enum logic [1:0] {
    SEQ_OFF     = 2'd0,
    SEQ_SAMPLE  = 2'd1,
    SEQ_LATCHED = 2'd2,
    SEQ_LIVE    = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic       sd_sel;
    logic       mode;
    logic [2:0] fs;
  } strap_t;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);

  // The count saturates at the window end and never runs past it.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // The count clears whenever the window is not running.
  assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned NPINS  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_raw,
  input  logic             load,
  input  logic             clear,
  output logic             stable,
  output logic [NPINS-1:0] held
);

  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] held_q, held_d;

  sync_chain #(.WIDTH(NPINS), .STAGES(STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  assign stable = (pin_s == prev_q);

  always_comb begin
    held_d = held_q;
    if (clear)     held_d = '0;
    else if (load) held_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held = held_q;

  // A load takes only a value that matched the sample before it.
  assert_load_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (pin_s == $past(pin_s)));

  // Held bits change only on a load or a clear.
  assert_held_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> $stable(held_q));

endmodule

// File: rtl/pinstrap_sequencer.sv
module pinstrap_sequencer
  import strap_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 28636,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic                 power_good,
  input  logic [PIN_COUNT-1:0] pin_sense,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic [2:0]           boot_fs,
  output logic                 mode_strap,
  output logic                 sdsel_strap,
  output logic                 clocks_live
);

  logic                 rst_int_n;
  logic                 pg_s;
  logic                 win_done;
  logic                 cap_stable;
  logic                 cap_load;
  logic                 cap_clear;
  logic [PIN_COUNT-1:0] cap_held;
  seq_state_t           state_q, state_d;
  strap_t               straps;

  sync_chain #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pg_sync (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .d     (power_good),
    .q     (pg_s)
  );

  window_timer #(.CYCLES(WIN_CYCLES)) u_timer (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .run   (state_q == SEQ_SAMPLE),
    .done  (win_done)
  );

  assign cap_load  = pg_s && (state_q == SEQ_SAMPLE) && win_done && cap_stable;
  assign cap_clear = !pg_s;

  strap_capture #(.NPINS(PIN_COUNT), .STAGES(SYNC_STAGES)) u_capture (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .pin_raw (pin_sense),
    .load    (cap_load),
    .clear   (cap_clear),
    .stable  (cap_stable),
    .held    (cap_held)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_OFF:     if (pg_s) state_d = SEQ_SAMPLE;
      SEQ_SAMPLE:  if (cap_load) state_d = SEQ_LATCHED;
      SEQ_LATCHED: state_d = SEQ_LIVE;
      SEQ_LIVE:    state_d = SEQ_LIVE;
      default:     state_d = SEQ_OFF;
    endcase
    if (!pg_s) state_d = SEQ_OFF;
  end

  always_ff @(posedge clk_ref or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= SEQ_OFF;
    else            state_q <= state_d;
  end

  assign straps.sd_sel = cap_held[PIN_REF];
  assign straps.mode   = cap_held[PIN_AGPF];
  assign straps.fs     = {cap_held[PIN_PCIF], cap_held[PIN_C48], cap_held[PIN_C24]};

  assign boot_fs     = straps.fs;
  assign mode_strap  = straps.mode;
  assign sdsel_strap = straps.sd_sel;
  assign clocks_live = (state_q == SEQ_LIVE);
  assign pin_oe      = {PIN_COUNT{clocks_live}};

  // Drivers come on only from the state entered on the latch edge.
  assert_enable_after_latch_R4: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    $rose(clocks_live) |-> $past(state_q) == SEQ_LATCHED);

  // The latched state is reached only through a completed window.
  assert_latch_after_window_R3: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    (state_q == SEQ_LATCHED) |-> $past(win_done));

  // Loss of power turns drivers off and clears the strap bits.
  assert_power_loss_clears_R7: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    !pg_s |=> (!clocks_live && cap_held == '0));

  // Straps stay fixed while the outputs are live.
  assert_straps_hold_live_R5: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    (clocks_live && $past(clocks_live)) |-> $stable(cap_held));

endmodule

// File: tb/tb_pinstrap_sequencer.sv
module tb_pinstrap_sequencer;

  localparam int W = 40;

  logic       clk_ref;
  logic       rst_n;
  logic       power_good;
  logic [4:0] pin_sense;
  logic [4:0] pin_oe;
  logic [2:0] boot_fs;
  logic       mode_strap;
  logic       sdsel_strap;
  logic       clocks_live;

  int total = 0;
  int bad   = 0;

  pinstrap_sequencer #(.WIN_CYCLES(W)) dut (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .power_good  (power_good),
    .pin_sense   (pin_sense),
    .pin_oe      (pin_oe),
    .boot_fs     (boot_fs),
    .mode_strap  (mode_strap),
    .sdsel_strap (sdsel_strap),
    .clocks_live (clocks_live)
  );

  initial clk_ref = 1'b0;
  always #5 clk_ref = ~clk_ref;

  // {sd_sel, mode, fs2, fs1, fs0} from pad levels
  function automatic logic [4:0] exp_straps(input logic [4:0] p);
    return {p[0], p[2], p[1], p[3], p[4]};
  endfunction

  function automatic logic [4:0] act_straps();
    return {sdsel_strap, mode_strap, boot_fs};
  endfunction

  task automatic chk(input string req, input logic [5:0] act_drv, input logic [5:0] exp_drv,
                     input logic [4:0] act_st, input logic [4:0] exp_st);
    total++;
    if (act_drv !== exp_drv || act_st !== exp_st) begin
      bad++;
      $display("FAIL %s: drivers act=%b exp=%b straps act=%b exp=%b",
               req, act_drv, exp_drv, act_st, exp_st);
    end
  endtask

  function automatic logic [5:0] drv();
    return {pin_oe, clocks_live};
  endfunction

  task automatic run_up(input logic [4:0] p0, input int tog_last);
    logic [4:0] p;
    int lat;
    string req;
    p   = p0;
    lat = W + 3;
    if (tog_last > 0 && tog_last + 4 > lat) lat = tog_last + 4;
    req = (tog_last > 0) ? "R6" : "R3";
    @(negedge clk_ref);
    pin_sense  = p;
    power_good = 1'b1;
    for (int e = 1; e <= lat + 1; e++) begin
      @(posedge clk_ref); #2;
      if (e == W / 2) chk("R2 mid-window", drv(), 6'b0, act_straps(), 5'b0);
      if (e == lat - 1) chk({req, " before load"}, drv(), 6'b0, act_straps(), 5'b0);
      if (e == lat) chk({req, " load edge, R4 drivers still off"}, drv(), 6'b0,
                        act_straps(), exp_straps(p));
      if (e == lat + 1) chk("R4 drivers on", drv(), 6'b111111, act_straps(), exp_straps(p));
      if (tog_last > 0 && e >= W - 5 && e <= tog_last) begin
        @(negedge clk_ref);
        p[2] = ~p[2];
        pin_sense = p;
      end
    end
  endtask

  task automatic live_hold(input int n);
    logic [4:0] keep;
    keep = act_straps();
    for (int i = 0; i < n; i++) begin
      @(negedge clk_ref);
      pin_sense = 5'($urandom);
      @(posedge clk_ref); #2;
      chk("R5 pads ignored", drv(), 6'b111111, act_straps(), keep);
    end
  endtask

  task automatic power_drop();
    logic [4:0] keep;
    keep = act_straps();
    @(negedge clk_ref);
    power_good = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk_ref); #2;
      if (e == 2) chk("R7 still live", drv(), 6'b111111, act_straps(), keep);
      if (e == 3) chk("R7 cleared", drv(), 6'b0, act_straps(), 5'b0);
    end
    repeat (3) @(posedge clk_ref);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    total++;
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n      = 1'b0;
    power_good = 1'b0;
    pin_sense  = 5'b10110;
    #12;
    chk("R1 reset", drv(), 6'b0, act_straps(), 5'b0);
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (4) @(posedge clk_ref);

    // directed corners
    run_up(5'b11111, 0);
    live_hold(6);
    power_drop();
    run_up(5'b00000, 0);
    power_drop();
    run_up(5'b01010, W - 1);
    live_hold(4);
    power_drop();
    run_up(5'b10101, W + 7);
    live_hold(4);

    // asynchronous reset while live
    @(negedge clk_ref);
    rst_n      = 1'b0;
    power_good = 1'b0;
    #1;
    chk("R1 reset while live", drv(), 6'b0, act_straps(), 5'b0);
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (4) @(posedge clk_ref);

    // random pad patterns and late settling
    for (int it = 0; it < 24; it++) begin
      logic [4:0] p;
      int tl;
      p  = 5'($urandom);
      tl = ($urandom_range(0, 1) == 1) ? (W - 5 + int'($urandom_range(0, 12))) : 0;
      run_up(p, tl);
      live_hold(int'($urandom_range(2, 6)));
      power_drop();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule